// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a circular list of receive descriptors held in memory. Each descriptor occupies 16 bytes: a command word at byte offset 0, a tag word at offset 4 that this block never reads, and the low and high halves of a 64-bit buffer address at offsets 8 and 12. When a frame arrives, the engine reads the command word of the current entry and checks who owns it. If the engine owns the entry, it fetches the buffer address and reports the buffer address and size to the data path. It then writes the command word back with ownership returned to the host and the stored length filled in, and moves on to the next entry.

Software programs the ring base through a single write port. The base must sit on a 256-byte boundary. If the engine finds the current entry still in host hands, it raises a one-cycle unavailable interrupt and stalls. It keeps the pending frame until the host pulses a restart. The memory side is a plain request/response port: a request is taken in the cycle it is raised, a read is answered later by a data-valid strobe, and a write needs no answer.

Top module: `rxring_engine`

## Requirements
- R1: Writing the base register stores the address with its low 8 bits forced to zero. It sets `cfg_err` when those 8 bits were non-zero and clears `cfg_err` otherwise. It also returns the ring position to entry 0.
- R2: For each accepted frame, the engine reads the command word at base + 16*index. For an owned entry it then reads the buffer address words at base + 16*index + 8 and base + 16*index + 12, and makes no other reads.
- R3: When bit 31 of the command word is 1 (engine-owned), `buf_valid` pulses for exactly one cycle. With it, `buf_addr` = {high word, low word} and `buf_size` = command bits 13:0.
- R4: After the report, the engine writes exactly one word, to the command word's address. It is the fetched command with bit 31 cleared, bit 30 unchanged, bit 21 set to the truncation flag, bits 13:0 set to the stored length, and all other bits unchanged.
- R5: When the frame length exceeds the buffer size, the stored length equals the buffer size, bit 21 of the written word is 1, and `buf_trunc` is high with `buf_valid`. Otherwise the stored length is the frame length and both flags are 0.
- R6: After a write-back, the index moves to 0 if bit 30 of the command was set or the index was RING_MAX-1. Otherwise it moves to index+1.
- R7: When bit 31 of the fetched command is 0, the engine pulses `rdu_irq` for one cycle. It then holds `stopped` high and issues no memory write and no further read until restarted.
- R8: A `restart` pulse while stopped reads the same entry again and serves the pending frame. A `restart` pulse while not stopped has no effect.
- R9: `frm_ready` is high only when the engine is idle and not stopped. The engine handles one frame at a time, and `frm_ready` is high after reset.
- R10: At most one memory read is outstanding, and no request is raised in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | MEM_AW | Ring base value |
| cfg_err | output | 1 | Last base write was not 256-byte aligned |
| restart | input | 1 | Host restart pulse after a stall |
| frm_valid | input | 1 | A frame is waiting |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_ready | output | 1 | Frame accepted when high with frm_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer report strobe |
| buf_addr | output | BUF_AW | Buffer address of the current entry |
| buf_size | output | 14 | Buffer size of the current entry |
| buf_trunc | output | 1 | Frame will be truncated |
| rdu_irq | output | 1 | Descriptor unavailable interrupt pulse |
| stopped | output | 1 | Engine stalled on a host-owned entry |

## Verification
A wrong ring index shows up at the very next frame, as a command read at an unexpected address and a report of another entry's buffer. A corrupted captured command word shows up in the same frame, in the written-back word and in `buf_size`. A wrong stall state shows up within a few cycles of the unavailable fetch: as a missing `rdu_irq`, a raised `frm_ready`, or a stray write. The bench runs random lengths around each buffer size over rings that wrap on the end flag and on the entry count. It adds directed cases for zero-size buffers, exact fits, unaligned bases, and restarts inside and outside a stall.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int DESC_BYTES = 16;
   localparam int SIZE_W     = 14;
   localparam int BIT_OWN    = 31;
   localparam int BIT_EOR    = 30;
   localparam int BIT_ERR    = 21;
   localparam int OFS_BLO    = 8;
   localparam int OFS_BHI    = 12;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_CMD,
      ST_WT_CMD,
      ST_RD_LO,
      ST_WT_LO,
      ST_RD_HI,
      ST_WT_HI,
      ST_REPORT,
      ST_WB,
      ST_STOP
   } rx_state_e;

   // command word handed back to the host after a frame
   function automatic logic [31:0] wb_word(input logic [31:0] cmd,
                                           input logic [SIZE_W-1:0] slen,
                                           input logic trunc);
      logic [31:0] w;
      w = cmd;
      w[BIT_OWN] = 1'b0;
      w[BIT_ERR] = trunc;
      w[SIZE_W-1:0] = slen;
      return w;
   endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
   import rxr_pkg::*;
#(
   parameter int MEM_AW     = 32,
   parameter int RING_MAX   = 1024,
   parameter int ALIGN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [MEM_AW-1:0] base_wdata,
   input  logic              advance,
   input  logic              eor,
   output logic              cfg_err,
   output logic [MEM_AW-1:0] desc_addr
);
   localparam int IDX_W   = $clog2(RING_MAX);
   localparam int DESC_SH = $clog2(DESC_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_MAX - 1);

   generate
      if (RING_MAX < 2 || RING_MAX > 1024) begin : g_bad_ring
         $error("RING_MAX must lie in 2..1024");
      end
      if (MEM_AW <= ALIGN_BITS || MEM_AW < IDX_W + DESC_SH) begin : g_bad_aw
         $error("MEM_AW too narrow for the ring");
      end
   endgenerate

   logic [MEM_AW-1:ALIGN_BITS] base_hi_q;
   logic [IDX_W-1:0]           idx_q;
   logic                       cfg_err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_hi_q <= '0;
         idx_q     <= '0;
         cfg_err_q <= 1'b0;
      end else if (base_wr) begin
         base_hi_q <= base_wdata[MEM_AW-1:ALIGN_BITS];
         cfg_err_q <= |base_wdata[ALIGN_BITS-1:0];
         idx_q     <= '0;
      end else if (advance) begin
         if (eor || idx_q == LAST_IDX)
            idx_q <= '0;
         else
            idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign cfg_err   = cfg_err_q;
   assign desc_addr = {base_hi_q, {ALIGN_BITS{1'b0}}} + (MEM_AW'(idx_q) << DESC_SH);

   AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (cfg_err == ($past(base_wdata[ALIGN_BITS-1:0]) != '0))); // R1
   AST_EOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      advance && eor && !base_wr |=> desc_addr == {base_hi_q, {ALIGN_BITS{1'b0}}}); // R6
   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !eor && !base_wr && idx_q != LAST_IDX
      |=> desc_addr == $past(desc_addr) + MEM_AW'(DESC_BYTES)); // R6
endmodule

// File: rtl/rxr_len_clip.sv
module rxr_len_clip
   import rxr_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [LEN_W-1:0]  frame_len,
   input  logic [SIZE_W-1:0] buf_size,
   output logic [SIZE_W-1:0] stored_len,
   output logic              trunc
);
   generate
      if (LEN_W > SIZE_W) begin : g_wide_len
         assign trunc = frame_len > LEN_W'(buf_size);
      end else begin : g_narrow_len
         assign trunc = SIZE_W'(frame_len) > buf_size;
      end
   endgenerate

   assign stored_len = trunc ? buf_size : SIZE_W'(frame_len);
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
   import rxr_pkg::*;
#(
   parameter int MEM_AW = 32,
   parameter int LEN_W  = 16,
   parameter int BUF_AW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              frm_ready,
   input  logic              restart,
   input  logic [MEM_AW-1:0] desc_addr,
   output logic              advance,
   output logic              cur_eor,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic [LEN_W-1:0]  len_o,
   output logic [SIZE_W-1:0] size_o,
   input  logic [SIZE_W-1:0] stored_len,
   input  logic              trunc,
   output logic              buf_valid,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [SIZE_W-1:0] buf_size,
   output logic              buf_trunc,
   output logic              rdu_irq,
   output logic              stopped
);
   localparam bit HAS_HI = (BUF_AW > 32);

   rx_state_e         st_q, st_d;
   logic [LEN_W-1:0]  len_q;
   logic [31:0]       cmd_q;
   logic [31:0]       lo_q;
   logic              rdu_q;
   logic              take_hi;

   always_comb begin
      st_d      = st_q;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_addr;
      mem_wdata = wb_word(cmd_q, stored_len, trunc);
      case (st_q)
         ST_IDLE:   if (frm_valid) st_d = ST_RD_CMD;
         ST_RD_CMD: begin
            mem_req = 1'b1;
            st_d    = ST_WT_CMD;
         end
         ST_WT_CMD: if (mem_rvalid) st_d = mem_rdata[BIT_OWN] ? ST_RD_LO : ST_STOP;
         ST_RD_LO: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + MEM_AW'(OFS_BLO);
            st_d     = ST_WT_LO;
         end
         ST_WT_LO:  if (mem_rvalid) st_d = HAS_HI ? ST_RD_HI : ST_REPORT;
         ST_RD_HI: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + MEM_AW'(OFS_BHI);
            st_d     = ST_WT_HI;
         end
         ST_WT_HI:  if (mem_rvalid) st_d = ST_REPORT;
         ST_REPORT: st_d = ST_WB;
         ST_WB: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            st_d    = ST_IDLE;
         end
         ST_STOP:   if (restart) st_d = ST_RD_CMD;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         cmd_q <= '0;
         lo_q  <= '0;
         rdu_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rdu_q <= (st_q == ST_WT_CMD) && mem_rvalid && !mem_rdata[BIT_OWN];
         if (st_q == ST_IDLE && frm_valid) len_q <= frm_len;
         if (st_q == ST_WT_CMD && mem_rvalid) cmd_q <= mem_rdata;
         if (st_q == ST_WT_LO && mem_rvalid) lo_q <= mem_rdata;
      end
   end

   assign take_hi = (st_q == ST_WT_HI) && mem_rvalid;

   generate
      if (BUF_AW < 32 || BUF_AW > 64) begin : g_bad_baw
         $error("BUF_AW must lie in 32..64");
      end
      if (HAS_HI) begin : g_wide_buf
         logic [31:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       hi_q <= '0;
            else if (take_hi) hi_q <= mem_rdata;
         end
         assign buf_addr = {hi_q[BUF_AW-33:0], lo_q};
      end else begin : g_narrow_buf
         assign buf_addr = lo_q[BUF_AW-1:0];
      end
   endgenerate

   assign frm_ready = (st_q == ST_IDLE);
   assign stopped   = (st_q == ST_STOP);
   assign buf_valid = (st_q == ST_REPORT);
   assign buf_trunc = buf_valid && trunc;
   assign buf_size  = cmd_q[SIZE_W-1:0];
   assign advance   = (st_q == ST_WB);
   assign cur_eor   = cmd_q[BIT_EOR];
   assign rdu_irq   = rdu_q;
   assign len_o     = len_q;
   assign size_o    = cmd_q[SIZE_W-1:0];

   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |=> !mem_req); // R10
   AST_WB_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[BIT_OWN]); // R4
   AST_BUF_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |=> mem_req && mem_we && !buf_valid); // R4
   AST_WB_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[SIZE_W-1:0] <= cmd_q[SIZE_W-1:0]); // R5
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && !restart |=> stopped && !mem_req); // R7
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rdu_irq |=> !rdu_irq); // R7
   AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && restart |=> mem_req && !mem_we); // R8
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
   import rxr_pkg::*;
#(
   parameter int MEM_AW   = 32,
   parameter int RING_MAX = 1024,
   parameter int LEN_W    = 16,
   parameter int BUF_AW   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [MEM_AW-1:0] base_wdata,
   output logic              cfg_err,
   input  logic              restart,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              frm_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              buf_valid,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [SIZE_W-1:0] buf_size,
   output logic              buf_trunc,
   output logic              rdu_irq,
   output logic              stopped
);
   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be positive");
      end
   endgenerate

   logic [MEM_AW-1:0] desc_addr;
   logic              advance;
   logic              cur_eor;
   logic [LEN_W-1:0]  len_q;
   logic [SIZE_W-1:0] size_q;
   logic [SIZE_W-1:0] stored_len;
   logic              trunc;

   rxr_ring_ptr #(
      .MEM_AW   (MEM_AW),
      .RING_MAX (RING_MAX)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_wr    (base_wr),
      .base_wdata (base_wdata),
      .advance    (advance),
      .eor        (cur_eor),
      .cfg_err    (cfg_err),
      .desc_addr  (desc_addr)
   );

   rxr_len_clip #(
      .LEN_W (LEN_W)
   ) u_clip (
      .frame_len  (len_q),
      .buf_size   (size_q),
      .stored_len (stored_len),
      .trunc      (trunc)
   );

   rxr_ctrl #(
      .MEM_AW (MEM_AW),
      .LEN_W  (LEN_W),
      .BUF_AW (BUF_AW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_valid  (frm_valid),
      .frm_len    (frm_len),
      .frm_ready  (frm_ready),
      .restart    (restart),
      .desc_addr  (desc_addr),
      .advance    (advance),
      .cur_eor    (cur_eor),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .len_o      (len_q),
      .size_o     (size_q),
      .stored_len (stored_len),
      .trunc      (trunc),
      .buf_valid  (buf_valid),
      .buf_addr   (buf_addr),
      .buf_size   (buf_size),
      .buf_trunc  (buf_trunc),
      .rdu_irq    (rdu_irq),
      .stopped    (stopped)
   );

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ready |-> !mem_req && !stopped); // R9
endmodule

// File: tb/rxring_engine_bench.sv
module rxring_engine_bench;
   localparam int AW = 16;
   localparam int RM = 8;
   localparam int LW = 16;
   localparam int BW = 64;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, base_wr, restart, frm_valid, cfg_err, frm_ready;
   logic [AW-1:0] base_wdata, mem_addr;
   logic [LW-1:0] frm_len;
   logic          mem_req, mem_we, mem_rvalid, buf_valid, buf_trunc, rdu_irq, stopped;
   logic [31:0]   mem_wdata, mem_rdata;
   logic [BW-1:0] buf_addr;
   logic [13:0]   buf_size;

   rxring_engine #(.MEM_AW(AW), .RING_MAX(RM), .LEN_W(LW), .BUF_AW(BW)) u_rxring_engine (
      .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata), .cfg_err(cfg_err),
      .restart(restart), .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_addr(buf_addr),
      .buf_size(buf_size), .buf_trunc(buf_trunc), .rdu_irq(rdu_irq), .stopped(stopped));

   int checks = 0;
   int fails = 0;
   logic [31:0] mem_w [0:1023];
   int rd_cnt = 0;
   logic [9:0] rd_widx;
   int wr_count = 0;
   int wr_mark = 0;
   int rd_n = 0;
   logic [AW-1:0] rd_hist [0:3];
   int exp_idx = 0;
   int cur_base = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] wb_exp(input logic [31:0] cmd, input int len);
      logic [31:0] w;
      int sz;
      sz = int'(cmd[13:0]);
      w = cmd;
      w[31] = 1'b0;
      w[21] = (len > sz);
      w[13:0] = (len > sz) ? cmd[13:0] : 14'(len);
      return w;
   endfunction

   // memory model: one read in flight, latency 1..3 cycles
   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_w[rd_widx];
            end
         end
         if (rst_n && mem_req) begin
            if (mem_we) begin
               mem_w[mem_addr[11:2]] = mem_wdata;
               wr_count++;
            end else begin
               if (rd_cnt != 0) chk(1'b0, "R10", "read while read pending", 1, 0);
               rd_widx = mem_addr[11:2];
               rd_cnt  = 1 + int'($urandom_range(2, 0));
               if (rd_n < 4) rd_hist[rd_n] = mem_addr;
               rd_n++;
            end
         end
      end
   end

   task automatic set_desc(input int idx, input bit own, input bit eor, input int size);
      int w;
      logic [31:0] cmd;
      w = cur_base / 4 + 4 * idx;
      cmd = $urandom;
      cmd[31] = own;
      cmd[30] = eor;
      cmd[13:0] = 14'(size);
      mem_w[w]     = cmd;
      mem_w[w + 1] = $urandom;
      mem_w[w + 2] = $urandom;
      mem_w[w + 3] = $urandom;
   endtask

   task automatic write_base(input logic [AW-1:0] v);
      base_wr = 1'b1;
      base_wdata = v;
      @(negedge clk);
      base_wr = 1'b0;
      cur_base = int'(v) & ~32'hFF;
      exp_idx = 0;
      chk(cfg_err == (v[7:0] != 0), "R1", "cfg_err after base write", cfg_err, v[7:0] != 0);
   endtask

   task automatic observe(input int len);
      int w, n, sz;
      logic [31:0] cmd, lo, hi;
      logic [AW-1:0] da;
      w = cur_base / 4 + 4 * exp_idx;
      da = AW'(cur_base + 16 * exp_idx);
      cmd = mem_w[w];
      lo = mem_w[w + 2];
      hi = mem_w[w + 3];
      sz = int'(cmd[13:0]);
      n = 0;
      while (!(buf_valid || rdu_irq) && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (cmd[31]) begin
         chk(buf_valid, "R3", "report strobe", buf_valid, 1);
         chk(buf_addr == {hi, lo}, "R3", "buffer address", buf_addr, {hi, lo});
         chk(buf_size == cmd[13:0], "R3", "buffer size", buf_size, cmd[13:0]);
         chk(buf_trunc == (len > sz), "R5", "truncation flag", buf_trunc, len > sz);
         @(negedge clk);
         chk(!buf_valid, "R3", "report strobe one cycle", buf_valid, 0);
         n = 0;
         while (!frm_ready && n < 50) begin
            @(negedge clk);
            n++;
         end
         chk(mem_w[w] == wb_exp(cmd, len), "R4", "written-back command", mem_w[w], wb_exp(cmd, len));
         chk(wr_count == wr_mark + 1, "R4", "write count per frame", wr_count - wr_mark, 1);
         chk(rd_n == 3, "R2", "reads per frame", rd_n, 3);
         chk(rd_hist[0] == da, "R2", "command read address", rd_hist[0], da);
         chk(rd_hist[1] == da + 8 && rd_hist[2] == da + 12, "R2", "buffer word addresses",
             {rd_hist[1], rd_hist[2]}, {da + AW'(8), da + AW'(12)});
         exp_idx = (cmd[30] || exp_idx == RM - 1) ? 0 : exp_idx + 1;  // R6
      end else begin
         chk(rdu_irq, "R7", "unavailable interrupt", rdu_irq, 1);
         chk(stopped, "R7", "stopped flag", stopped, 1);
         chk(!frm_ready, "R9", "not ready while stopped", frm_ready, 0);
         chk(rd_hist[0] == da, "R2", "command read address", rd_hist[0], da);
         @(negedge clk);
         chk(!rdu_irq, "R7", "interrupt one cycle", rdu_irq, 0);
         repeat (4) @(negedge clk);
         chk(wr_count == wr_mark && rd_n == 1, "R7", "no memory access while stopped",
             {32'(wr_count - wr_mark), 32'(rd_n)}, {32'd0, 32'd1});
         chk(stopped, "R7", "still stopped", stopped, 1);
      end
   endtask

   task automatic send(input int len);
      int n;
      n = 0;
      while (!frm_ready && n < 200) begin
         @(negedge clk);
         n++;
      end
      rd_n = 0;
      wr_mark = wr_count;
      frm_valid = 1'b1;
      frm_len = LW'(len);
      @(negedge clk);
      frm_valid = 1'b0;
      observe(len);
   endtask

   task automatic rand_frame(input bit eor);
      int sz, len;
      sz = 64 + int'($urandom_range(1900, 0));
      set_desc(exp_idx, 1'b1, eor, sz);
      len = int'($urandom_range(sz + 40, 1));
      send(len);
   endtask

   initial begin
      bit done;
      done = 1'b0;
      void'($urandom(32'd4242));
      for (int i = 0; i < 1024; i++) mem_w[i] = '0;
      rst_n = 1'b0; base_wr = 1'b0; base_wdata = '0; restart = 1'b0;
      frm_valid = 1'b0; frm_len = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_ready, "R9", "ready after reset", frm_ready, 1);
      chk(!stopped && !cfg_err && !rdu_irq, "R7", "flags clear after reset",
          {stopped, cfg_err, rdu_irq}, 0);
      chk(!mem_req && !buf_valid, "R10", "bus quiet after reset", {mem_req, buf_valid}, 0);

      // end flag on entry 4: ring of five entries
      write_base(16'h0100);
      for (int f = 0; f < 12; f++) rand_frame(exp_idx == 4);

      // truncation corners
      set_desc(exp_idx, 1'b1, 1'b0, 0);
      send(5);                               // R5 zero-size buffer
      set_desc(exp_idx, 1'b1, 1'b0, 300);
      send(300);                             // R5 exact fit
      set_desc(exp_idx, 1'b1, 1'b0, 300);
      send(301);                             // R5 one over
      set_desc(exp_idx, 1'b1, 1'b0, 16383);
      send(65535);                           // R5 longest length

      // restart while running is ignored
      rd_n = 0;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      repeat (4) @(negedge clk);
      chk(rd_n == 0 && !stopped && frm_ready, "R8", "idle restart ignored",
          {32'(rd_n), 31'd0, stopped}, 0);
      rand_frame(1'b0);

      // host-owned entry: stall, then restart on the same entry
      set_desc(exp_idx, 1'b0, 1'b0, 100);
      send(50);
      frm_valid = 1'b1;
      frm_len = 16'd7;
      repeat (3) @(negedge clk);
      frm_valid = 1'b0;
      chk(stopped && !frm_ready && rd_n == 1, "R9", "new frame refused while stopped",
          {stopped, frm_ready}, 2'b10);
      set_desc(exp_idx, 1'b1, 1'b0, 30);
      rd_n = 0;
      wr_mark = wr_count;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      observe(50);                           // R8 pending frame served, truncated
      chk(!stopped, "R8", "running after restart", stopped, 0);

      // unaligned base, wrap on ring size
      write_base(16'h02A7);
      for (int f = 0; f < 10; f++) rand_frame(1'b0);
      write_base(16'h0300);
      rand_frame(1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL ALL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule